// File: doc/BRIEF.md
# Boundary-Scan Test Access Controller

This block is the test logic that sits between a four-wire serial test port (plus an optional active-low asynchronous reset) and a small core. A sixteen-state controller follows the mode-select input on each rising test-clock edge. That controller steers three things: a 4-bit instruction register, a chain of boundary cells that sit between the core's parallel pins and the outside world, and two simple data registers (a one-bit bypass stage and a 26-bit identification register). Serial data enters on `tdi`. The output `tdo` changes on the falling test-clock edge and is enabled only while a register is being shifted.

A board tester uses the block in this order. It loads an instruction, then runs data-register scans. With the sample/preload instruction it reads the live pin values and preloads a pattern. With the external-test instruction it takes control of the pins and drives scanned-in values onto them. With the identification instruction it reads a fixed code. With the bypass instruction the whole chip shrinks to a single stage in the board chain. Every register is shifted least significant bit first: the bit entering from `tdi` goes into the top position, and bit 0 appears on `tdo`.

Top module: `scan_test_ctrl`

## Requirements
- R1: The controller moves between its 16 states on rising `tck` edges under `tms`. Five consecutive edges with `tms` high bring it to the reset state from any state. Every data or instruction scan may pass through the pause states without losing shifted bits.
- R2: Driving `trst_n` low forces the reset state and clears `tdo_en` at once, without a clock edge. While in the reset state the active instruction becomes identification (low bits 2'b10).
- R3: The instruction register is 4 bits wide. The capture state loads 4'b0001, so the first four bits seen on `tdo` during an instruction shift are 1, 0, 0, 0. The shifted value becomes the active instruction on the edge that leaves the instruction-update state.
- R4: Only instruction bits [1:0] are decoded: 2'b00 external test, 2'b01 sample/preload, 2'b10 identification, 2'b11 bypass. Bits [3:2] have no effect.
- R5: Under identification, a data scan captures the 26-bit code ID_CODE (default 26'h15A3C97) and shifts it out bit 0 first.
- R6: Under bypass, the data path is one stage that captures 0. The bit seen on `tdo` on each shift is the `tdi` bit from the shift before.
- R7: Under external test or sample/preload, the data-capture state loads `pin_in` into the boundary cells, and cell 0 is shifted out first.
- R8: The update stages of the boundary cells load on the edge that leaves the data-update state. `pin_out` equals the update stages under external test and equals `pin_in` under any other instruction. Under external test, `pin_out` does not change while a scan shifts.
- R9: `tdo` is registered on the falling edge of `tck`. `tdo_en` is high only in the two shift states, and `tdo` reads 0 while `tdo_en` is low.
- R10: A pattern preloaded under sample/preload appears on `pin_out` as soon as external test becomes the active instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shifted data |
| pin_in | input | BS_N | Parallel values arriving at the boundary cells |
| pin_out | output | BS_N | Parallel values leaving the boundary cells |

## Verification
Under external test, one data scan does two things: it captures the present `pin_in` value, and the same register keeps driving `pin_out` from the pattern updated by the previous scan. The bench sweeps all sixteen pin values. Before each scan it sets `pin_in` to one value, shifts in that value's complement, and samples `pin_out` on every shift step. A step counts as an error if `pin_out` moves before the update edge, if the captured bits differ from the pins, or if `pin_out` does not show the complement after the update edge.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SHIFT_DR,
        ST_EXIT1_DR,
        ST_PAUSE_DR,
        ST_EXIT2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SHIFT_IR,
        ST_EXIT1_IR,
        ST_PAUSE_IR,
        ST_EXIT2_IR,
        ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        OP_EXTEST = 2'b00,
        OP_SAMPLE = 2'b01,
        OP_IDCODE = 2'b10,
        OP_BYPASS = 2'b11
    } op_e;

    typedef struct packed {
        logic bit_v;
        logic en;
    } tdo_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_d = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   state_d = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   state_d = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: state_d = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: state_d = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: state_d = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: state_d = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   state_d = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   state_d = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   state_d = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: state_d = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: state_d = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: state_d = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: state_d = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   state_d = tms ? ST_SEL_DR   : ST_IDLE;
            default:     state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/tap_ir.sv
module tap_ir #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    CAP_VAL = W'(1),
    parameter logic [W-1:0]    RST_VAL = W'(2)
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tdi,
    input  logic         cap,
    input  logic         shift,
    input  logic         upd,
    input  logic         tap_rst,
    output logic [W-1:0] shreg,
    output logic [W-1:0] instr
);
    typedef struct packed {
        logic [W-1:0] sr;
        logic [W-1:0] hold;
    } ir_t;

    ir_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        if (cap)        ir_d.sr = CAP_VAL;
        else if (shift) ir_d.sr = (ir_q.sr >> 1) | (W'(tdi) << (W - 1));
        if (upd)          ir_d.hold = ir_q.sr;
        else if (tap_rst) ir_d.hold = RST_VAL;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_q.sr   <= '0;
            ir_q.hold <= RST_VAL;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign shreg = ir_q.sr;
    assign instr = ir_q.hold;
endmodule

// File: rtl/tap_shreg.sv
module tap_shreg #(
    parameter int W = 1
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tdi,
    input  logic         cap,
    input  logic         shift,
    input  logic [W-1:0] cap_val,
    output logic         so
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (cap)        sr_d = cap_val;
        else if (shift) sr_d = (sr_q >> 1) | (W'(tdi) << (W - 1));
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) sr_q <= '0;
        else         sr_q <= sr_d;
    end

    assign so = sr_q[0];
endmodule

// File: rtl/tap_bsr.sv
module tap_bsr #(
    parameter int N = 4
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tdi,
    input  logic         cap,
    input  logic         shift,
    input  logic         upd,
    input  logic         test_mode,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pin_out,
    output logic         so
);
    typedef struct packed {
        logic [N-1:0] cap;
        logic [N-1:0] upd;
    } bsr_t;

    bsr_t        bs_d, bs_q;
    logic [N-1:0] chain_in;

    for (genvar i = 0; i < N; i++) begin : g_cell
        if (i == N - 1) begin : g_head
            assign chain_in[i] = tdi;
        end else begin : g_link
            assign chain_in[i] = bs_q.cap[i+1];
        end
        assign pin_out[i] = test_mode ? bs_q.upd[i] : pin_in[i];
    end

    always_comb begin
        bs_d = bs_q;
        for (int i = 0; i < N; i++) begin
            if (cap)        bs_d.cap[i] = pin_in[i];
            else if (shift) bs_d.cap[i] = chain_in[i];
        end
        if (upd) bs_d.upd = bs_q.cap;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) bs_q <= '0;
        else         bs_q <= bs_d;
    end

    assign so = bs_q.cap[0];
endmodule

// File: rtl/scan_test_ctrl.sv
module scan_test_ctrl
    import tap_pkg::*;
#(
    parameter int              IR_W    = 4,
    parameter int              ID_W    = 26,
    parameter int              BS_N    = 4,
    parameter logic [ID_W-1:0] ID_CODE = 26'h15A3C97
) (
    input  logic            tck,
    input  logic            tms,
    input  logic            tdi,
    input  logic            trst_n,
    output logic            tdo,
    output logic            tdo_en,
    input  logic [BS_N-1:0] pin_in,
    output logic [BS_N-1:0] pin_out
);
    localparam logic [IR_W-1:0] IR_CAP = IR_W'(1);
    localparam logic [IR_W-1:0] IR_RST = IR_W'(OP_IDCODE);

    tap_state_e      state;
    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_instr;
    op_e             op;
    logic            sel_bsr, sel_id, sel_byp, test_mode, in_ir;
    logic            cap_dr, shift_dr, upd_dr;
    logic            bsr_so, id_so, byp_so, dr_so;
    tdo_t            out_d, out_q;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    assign op        = op_e'(ir_instr[1:0]);
    assign sel_bsr   = (op == OP_EXTEST) || (op == OP_SAMPLE);
    assign sel_id    = (op == OP_IDCODE);
    assign sel_byp   = (op == OP_BYPASS);
    assign test_mode = (op == OP_EXTEST);
    assign cap_dr    = (state == ST_CAP_DR);
    assign shift_dr  = (state == ST_SHIFT_DR);
    assign upd_dr    = (state == ST_UPD_DR);
    assign in_ir     = state inside {ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR,
                                     ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR};

    tap_ir #(.W(IR_W), .CAP_VAL(IR_CAP), .RST_VAL(IR_RST)) u_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .cap     (state == ST_CAP_IR),
        .shift   (state == ST_SHIFT_IR),
        .upd     (state == ST_UPD_IR),
        .tap_rst (state == ST_RESET),
        .shreg   (ir_sr),
        .instr   (ir_instr)
    );

    tap_shreg #(.W(ID_W)) u_id (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .cap     (cap_dr && sel_id),
        .shift   (shift_dr && sel_id),
        .cap_val (ID_CODE),
        .so      (id_so)
    );

    tap_shreg #(.W(1)) u_byp (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .cap     (cap_dr && sel_byp),
        .shift   (shift_dr && sel_byp),
        .cap_val (1'b0),
        .so      (byp_so)
    );

    tap_bsr #(.N(BS_N)) u_bsr (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .cap       (cap_dr && sel_bsr),
        .shift     (shift_dr && sel_bsr),
        .upd       (upd_dr && sel_bsr),
        .test_mode (test_mode),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .so        (bsr_so)
    );

    always_comb begin
        if (sel_bsr)     dr_so = bsr_so;
        else if (sel_id) dr_so = id_so;
        else             dr_so = byp_so;
        out_d.bit_v = in_ir ? ir_sr[0] : dr_so;
        out_d.en    = (state == ST_SHIFT_DR) || (state == ST_SHIFT_IR);
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) out_q <= '0;
        else         out_q <= out_d;
    end

    assign tdo    = out_q.en & out_q.bit_v;
    assign tdo_en = out_q.en;
endmodule

// File: rtl/scan_test_ctrl_chk.sv
module scan_test_ctrl_chk
    import tap_pkg::*;
#(
    parameter int IR_W = 4,
    parameter int BS_N = 4
) (
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input logic            tdo_en,
    input logic [BS_N-1:0] pin_out,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_sr,
    input logic [IR_W-1:0] ir_instr,
    input logic            test_mode
);
    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)        ones_q <= '0;
        else if (!tms)      ones_q <= '0;
        else if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
    end

    assert_tms_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q >= 3'd5) |-> (state == ST_RESET));

    always @(posedge tck) begin
        if (!trst_n) begin
            assert_async_reset_R2: assert (state == ST_RESET && !tdo_en);
        end
    end

    assert_reset_instr_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (ir_instr[1:0] == 2'b10));

    assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

    assert_pins_hold_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (test_mode && state != ST_UPD_DR && state != ST_UPD_IR && state != ST_RESET)
        |=> $stable(pin_out));

    assert_en_in_shift_R9: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SHIFT_DR || state == ST_SHIFT_IR));
endmodule

bind scan_test_ctrl scan_test_ctrl_chk #(.IR_W(IR_W), .BS_N(BS_N)) u_chk (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .tdo_en    (tdo_en),
    .pin_out   (pin_out),
    .state     (state),
    .ir_sr     (ir_sr),
    .ir_instr  (ir_instr),
    .test_mode (test_mode)
);

// File: tb/sim_scan_test_ctrl.sv
module sim_scan_test_ctrl;
    localparam logic [25:0] ID_EXP = 26'h15A3C97;

    logic       tck = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       trst_n = 1'b0;
    logic [3:0] pin_in = 4'h0;
    logic       tdo, tdo_en;
    logic [3:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    scan_test_ctrl u0 (
        .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n),
        .tdo(tdo), .tdo_en(tdo_en), .pin_in(pin_in), .pin_out(pin_out)
    );

    always #4 tck = ~tck;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o, output logic en);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        o   = tdo;
        en  = tdo_en;
        @(posedge tck);
        #1;
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, input int pause_at,
                           output logic [63:0] dout, output int en_bad, output int po_moves);
        logic o, e;
        logic [3:0] po0;
        dout = '0; en_bad = 0; po_moves = 0;
        po0 = pin_out;
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        for (int i = 0; i < n; i++) begin
            step((i == n - 1 || i == pause_at) ? 1'b1 : 1'b0, din[i], o, e);
            dout[i] = o;
            if (!e) en_bad++;
            if (pin_out !== po0) po_moves++;
            if (i == pause_at && i != n - 1) begin
                step(1'b0, 1'b0, o, e);
                if (e) en_bad++;
                step(1'b1, 1'b0, o, e);
                step(1'b0, 1'b0, o, e);
            end
        end
        step(1'b1, 1'b0, o, e);
        if (pin_out !== po0) po_moves++;
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic scan_ir(input logic [3:0] din, output logic [3:0] dout);
        logic o, e;
        dout = '0;
        step(1'b1, 1'b0, o, e);
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        for (int i = 0; i < 4; i++) begin
            step((i == 3) ? 1'b1 : 1'b0, din[i], o, e);
            dout[i] = o;
        end
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] dout;
        logic [3:0]  irout;
        int          en_bad, po_moves;
        logic        o, e;

        #20;
        check("R9 tdo_en low in reset", {63'd0, tdo_en}, 64'd0);
        @(negedge tck); #1; trst_n = 1'b1;
        step(1'b0, 1'b0, o, e);

        // R2 R5: identification active after reset
        scan_dr(26, 64'd0, -1, dout, en_bad, po_moves);
        check("R5 id code after reset", dout, {38'd0, ID_EXP});
        check("R9 tdo_en high in shift", 64'(en_bad), 64'd0);

        // R1: identification scan split by the pause states
        scan_dr(26, 64'd0, 9, dout, en_bad, po_moves);
        check("R1 id code through pause", dout, {38'd0, ID_EXP});
        check("R9 tdo_en only in shift", 64'(en_bad), 64'd0);

        // R3: capture pattern, load sample/preload
        scan_ir(4'b0001, irout);
        check("R3 ir capture 0001", {60'd0, irout}, 64'h1);

        // R7 R8: sample/preload capture and preload
        pin_in = 4'b1010;
        scan_dr(4, 64'b0110, -1, dout, en_bad, po_moves);
        check("R7 sample capture", dout, 64'b1010);
        check("R8 normal pass-through", {60'd0, pin_out}, {60'd0, pin_in});

        // R10 R4: external test via 0100 (upper bits ignored)
        scan_ir(4'b0100, irout);
        check("R10 preload driven on extest", {60'd0, pin_out}, 64'b0110);
        check("R3 ir capture again", {60'd0, irout}, 64'h1);

        // R7 R8: exhaustive pin sweep under external test
        for (int v = 0; v < 16; v++) begin
            pin_in = 4'(v);
            scan_dr(4, 64'(~v & 15), -1, dout, en_bad, po_moves);
            check("R7 extest capture", dout, 64'(v));
            check("R8 extest drive after update", {60'd0, pin_out}, 64'(~v & 15));
            check("R8 pins hold during shift", 64'(po_moves), 64'd0);
        end

        // R4 R6: bypass selected by 1111
        scan_ir(4'b1111, irout);
        check("R8 bypass leaves pins to pin_in", {60'd0, pin_out}, {60'd0, pin_in});
        scan_dr(8, 64'hB2, -1, dout, en_bad, po_moves);
        check("R6 bypass one-bit delay", dout, {56'd0, 8'hB2 << 1});

        // R4: 0110 decodes as identification
        scan_ir(4'b0110, irout);
        scan_dr(26, 64'd0, -1, dout, en_bad, po_moves);
        check("R4 upper bits ignored idcode", dout, {38'd0, ID_EXP});

        // R1: five tms-high edges return to reset
        scan_ir(4'b0011, irout);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        scan_dr(26, 64'd0, -1, dout, en_bad, po_moves);
        check("R1 tms reset restores idcode", dout, {38'd0, ID_EXP});

        // R2: asynchronous reset mid-shift
        scan_ir(4'b0011, irout);
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        @(negedge tck); #2;
        check("R9 tdo_en in shift before trst", {63'd0, tdo_en}, 64'd1);
        trst_n = 1'b0;
        #1;
        check("R2 async clear of tdo_en", {63'd0, tdo_en}, 64'd0);
        @(negedge tck); #1; trst_n = 1'b1; tms = 1'b0;
        @(posedge tck); #1;
        scan_dr(26, 64'd0, -1, dout, en_bad, po_moves);
        check("R2 idcode after async reset", dout, {38'd0, ID_EXP});

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule